// File: doc/BRIEF.md
# Composite Sync Vertical Separator

This block recovers the vertical sync interval from a digital composite sync stream. A two-way source select chooses the composite signal: either the horizontal sync input or the sliced sync-on-green signal. The chosen level is brought into a slow, separate timebase of about 5 MHz through a two-register synchroniser. It then goes through a persistence filter. The output only takes on a new level after the input has held that level for a programmed number of consecutive timebase ticks.

The normal horizontal pulses are short compared with the window, and so are the serration pulses inside the vertical interval. The filter drops all of them. Only the long vertical interval reaches the output. The window length is an 8-bit tick count that is loaded through a write strobe, and it comes out of reset at 32 ticks. Changing the source or the window length restarts the persistence count but leaves the output level alone. A length of zero turns the filter into a plain pass-through of the synchronised level.

Top module: `csync_vsep`

## Requirements
- R1: After reset the output `vsync_o` is low and the window length is 32 ticks, so that a 31-tick input level is rejected and a 32-tick level passes.
- R2: `src_sel` = 0 feeds `hs_in` to the filter and `src_sel` = 1 feeds `sog_in`; activity on the input that is not selected has no effect on `vsync_o`.
- R3: The selected input passes through two timebase registers before filtering. With a length N ≥ 1, an input change first sampled at rising edge k shows on `vsync_o` after rising edge k+N+1.
- R4: A level that differs from `vsync_o` and lasts fewer than N consecutive ticks is rejected, and `vsync_o` keeps its previous level.
- R5: The persistence count restarts whenever the synchronised input returns to the output level, so separate short excursions never add up to a pass.
- R6: With a length of 0, `vsync_o` follows the synchronised input with one extra tick of latency, so a change sampled at edge k appears after edge k+2.
- R7: A tick with `len_we` high loads `len_val` as the new window length; any value from 0 to 255 is valid, and 255 rejects a 254-tick level while passing a 255-tick level.
- R8: A tick on which `src_sel` differs from its previous value, or on which `len_we` writes a length different from the current one, clears the persistence count and holds `vsync_o` unchanged.
- R9: The return edge is filtered the same way as the leading edge: `vsync_o` goes back only after the input has held the original level for N ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter timebase clock (about 5 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_in | input | 1 | Horizontal or composite sync input (asynchronous) |
| sog_in | input | 1 | Sliced sync-on-green composite input (asynchronous) |
| src_sel | input | 1 | Composite source select: 0 horizontal sync input, 1 sync-on-green |
| len_we | input | 1 | Write strobe for the window length |
| len_val | input | 8 | Window length in ticks, loaded when `len_we` is high |
| vsync_o | output | 1 | Filtered vertical sync |

## Verification
The assertions assume that `len_val` is stable whenever `len_we` is high, and that `src_sel` changes at most once per tick. They also assume that the composite inputs are plain levels whose only timing relation to the timebase is the one the synchroniser absorbs. The bench changes every input on the falling clock edge, holds each level for whole ticks, and writes the length with a single-tick strobe. Each assumption is therefore met by construction of the stimulus. The reference model only has to follow the input two ticks late and count how long it has disagreed with the output.

// File: rtl/csync_pkg.sv
package csync_pkg;

  typedef enum logic {
    SRC_HSYNC = 1'b0,
    SRC_SOG   = 1'b1
  } csync_src_e;

  // True when one more disagreeing tick completes a window of len ticks.
  function automatic logic run_complete(input int unsigned run, input int unsigned len);
    return (run + 1) >= len;
  endfunction

  // A configuration change is a new source, or a write of a different length.
  function automatic logic cfg_differs(input logic sel_now, input logic sel_prev,
                                       input logic wr, input int unsigned len_new,
                                       input int unsigned len_cur);
    return (sel_now != sel_prev) || (wr && (len_new != len_cur));
  endfunction

endpackage

// File: rtl/csync_src_sync.sv
module csync_src_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic hs_in,
  input  logic sog_in,
  output logic lvl_o
);
  import csync_pkg::*;

  logic raw;
  logic [STAGES-1:0] chain_q;

  assign raw = (csync_src_e'(sel) == SRC_SOG) ? sog_in : hs_in;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= raw;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], raw};
      end
    end
  endgenerate

  assign lvl_o = chain_q[STAGES-1];

endmodule

// File: rtl/csync_cfg.sv
module csync_cfg #(
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned DEF_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [LEN_W-1:0] len_new,
  output logic [LEN_W-1:0] len_o,
  output logic             chg_o
);
  import csync_pkg::*;

  logic             sel_q;
  logic [LEN_W-1:0] len_q;

  assign chg_o = cfg_differs(sel, sel_q, wr, 32'(len_new), 32'(len_q));
  assign len_o = len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      len_q <= LEN_W'(DEF_LEN);
    end else begin
      sel_q <= sel;
      if (wr) len_q <= len_new;
    end
  end

endmodule

// File: rtl/csync_persist.sv
module csync_persist #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             clr_i,
  output logic             out_o,
  output logic [LEN_W-1:0] cnt_o,
  output logic             flip_o
);
  import csync_pkg::*;

  logic             out_q;
  logic [LEN_W-1:0] cnt_q;
  logic             differ;
  logic             bypass;
  logic             done;

  assign differ = (lvl_i != out_q);
  assign bypass = (len_i == '0);
  assign done   = run_complete(32'(cnt_q), 32'(len_i));
  assign flip_o = !clr_i && differ && (bypass || done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (bypass) begin
      out_q <= lvl_i;
      cnt_q <= '0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (done) begin
      out_q <= ~out_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign out_o = out_q;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/csync_vsep.sv
module csync_vsep #(
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned DEF_LEN     = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_in,
  input  logic             sog_in,
  input  logic             src_sel,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_val,
  output logic             vsync_o
);

  logic             sync_lvl;
  logic             cfg_chg;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] run_cnt;
  logic             flip_evt;

  csync_src_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (src_sel),
    .hs_in  (hs_in),
    .sog_in (sog_in),
    .lvl_o  (sync_lvl)
  );

  csync_cfg #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (src_sel),
    .wr      (len_we),
    .len_new (len_val),
    .len_o   (len_q),
    .chg_o   (cfg_chg)
  );

  csync_persist #(.LEN_W(LEN_W)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (sync_lvl),
    .len_i  (len_q),
    .clr_i  (cfg_chg),
    .out_o  (vsync_o),
    .cnt_o  (run_cnt),
    .flip_o (flip_evt)
  );

endmodule

// File: rtl/csync_vsep_chk.sv
module csync_vsep_chk #(
  parameter int unsigned LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             len_we,
  input logic [LEN_W-1:0] len_val,
  input logic             vsync_o,
  input logic             sync_lvl,
  input logic             cfg_chg,
  input logic [LEN_W-1:0] len_q,
  input logic [LEN_W-1:0] run_cnt,
  input logic             flip_evt
);

  p_cfg_holds_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> vsync_o == $past(vsync_o));

  p_cfg_clears_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> run_cnt == '0);

  p_match_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lvl == vsync_o) |=> run_cnt == '0);

  p_change_needs_diff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_o != $past(vsync_o)) |-> ($past(sync_lvl) != $past(vsync_o)));

  p_cnt_below_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) |-> (run_cnt < len_q));

  p_len_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    len_we |=> len_q == $past(len_val));

  p_full_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_evt && len_q != '0) |-> (32'(run_cnt) + 1 == 32'(len_q)));

  p_zero_len_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == '0 && !cfg_chg) |=> vsync_o == $past(sync_lvl));

endmodule

bind csync_vsep csync_vsep_chk #(.LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .len_we   (len_we),
  .len_val  (len_val),
  .vsync_o  (vsync_o),
  .sync_lvl (sync_lvl),
  .cfg_chg  (cfg_chg),
  .len_q    (len_q),
  .run_cnt  (run_cnt),
  .flip_evt (flip_evt)
);

// File: tb/csync_vsep_bench.sv
module csync_vsep_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_in = 1'b0;
  logic       sog_in = 1'b0;
  logic       src_sel = 1'b0;
  logic       len_we = 1'b0;
  logic [7:0] len_val = 8'd0;
  logic       vsync_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  lvl;
    string req;
  } item_t;
  item_t sb[$];

  // Reference state: input seen one and two ticks late, output, window, run length.
  logic m_late1 = 1'b0, m_late2 = 1'b0, m_vs = 1'b0, m_prev_sel = 1'b0;
  int   m_win = 32;
  int   m_held = 0;

  always #5 clk = ~clk;

  csync_vsep u_csync_vsep (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .sog_in(sog_in),
    .src_sel(src_sel), .len_we(len_we), .len_val(len_val), .vsync_o(vsync_o)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: vsync_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: one tick of stimulus, and the level expected after the coming edge.
  task automatic tick(input logic h, input logic s, input logic sel,
                      input logic we, input logic [7:0] v, input string req);
    logic picked, restart, nxt;
    @(negedge clk);
    hs_in = h; sog_in = s; src_sel = sel; len_we = we; len_val = v;
    picked  = sel ? s : h;
    restart = (sel != m_prev_sel) || (we && int'(v) != m_win);
    nxt = m_vs;
    if (restart) m_held = 0;
    else if (m_win == 0) begin nxt = m_late2; m_held = 0; end
    else if (m_late2 == m_vs) m_held = 0;
    else begin
      m_held = m_held + 1;
      if (m_held == m_win) begin nxt = ~m_vs; m_held = 0; end
    end
    m_vs = nxt;
    m_late2 = m_late1;
    m_late1 = picked;
    m_prev_sel = sel;
    if (we) m_win = int'(v);
    sb.push_back('{nxt, req});
  endtask

  task automatic hold(input logic h, input logic s, input logic sel, input int n,
                      input string req);
    for (int i = 0; i < n; i++) tick(h, s, sel, 1'b0, 8'd0, req);
  endtask

  task automatic set_len(input logic [7:0] v, input logic sel, input string req);
    tick(1'b0, 1'b0, sel, 1'b1, v, req);
  endtask

  // Monitor: compares after each rising edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(vsync_o, it.lvl, it.req);
    end
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(vsync_o, 1'b0, "R1 reset level");
    @(negedge clk);
    rst_n = 1'b1;
    hold(0, 0, 0, 4, "R1 idle");
    // Default window 32: 31 rejected, 32 passes (R1, R3, R4)
    hold(1, 0, 0, 31, "R1 R4 31-tick reject");
    hold(0, 0, 0, 40, "R1 R4 settle");
    hold(1, 0, 0, 32, "R1 R3 32-tick pass");
    hold(1, 0, 0, 6, "R3 high held");
    // Return edge filtered the same way (R9)
    hold(0, 0, 0, 31, "R9 return wait");
    hold(0, 0, 0, 6, "R9 return done");
    // Unselected sync-on-green ignored (R2)
    hold(0, 1, 0, 50, "R2 sog ignored");
    // Switch source with sog high: restart, then pass (R8, R2)
    hold(0, 1, 1, 1, "R8 source switch hold");
    hold(0, 1, 1, 40, "R2 sog selected");
    hold(1, 0, 1, 40, "R2 hs ignored on sog");
    hold(0, 0, 1, 1, "R5 prep");
    // Separate excursions never add up (R5)
    hold(1, 0, 0, 1, "R8 back to hs");
    hold(0, 0, 0, 5, "R5 settle");
    hold(1, 0, 0, 20, "R5 first part");
    hold(0, 0, 0, 2, "R5 gap");
    hold(1, 0, 0, 20, "R5 second part");
    hold(0, 0, 0, 30, "R5 settle2");
    // Zero length: pass-through with latency (R6)
    set_len(8'd0, 0, "R7 write 0");
    hold(1, 0, 0, 1, "R6 pulse");
    hold(0, 0, 0, 3, "R6 gap");
    hold(1, 0, 0, 3, "R6 pulse3");
    hold(0, 0, 0, 5, "R6 settle");
    // Length 3 (R7, R4)
    set_len(8'd3, 0, "R7 write 3");
    hold(1, 0, 0, 2, "R4 2-tick reject");
    hold(0, 0, 0, 5, "R4 settle");
    hold(1, 0, 0, 3, "R7 3-tick pass");
    hold(0, 0, 0, 6, "R9 len3 return");
    // Length 255 (R7)
    set_len(8'd255, 0, "R7 write 255");
    hold(1, 0, 0, 254, "R7 254 reject");
    hold(0, 0, 0, 4, "R7 settle");
    hold(1, 0, 0, 255, "R7 255 pass");
    hold(1, 0, 0, 4, "R7 255 high");
    hold(0, 0, 0, 260, "R9 255 return");
    // Length change mid-run restarts count (R8)
    set_len(8'd10, 0, "R7 write 10");
    hold(1, 0, 0, 8, "R8 partial run");
    tick(1, 0, 0, 1'b1, 8'd10, "R8 same length no restart");
    hold(1, 0, 0, 3, "R8 completes at 10");
    hold(0, 0, 0, 8, "R8 partial low");
    tick(0, 0, 0, 1'b1, 8'd12, "R8 new length restart");
    hold(0, 0, 0, 10, "R8 still high");
    hold(0, 0, 0, 6, "R8 falls after 12");
    hold(0, 0, 0, 4, "R8 end");
    wait (sb.size() == 0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule